// File: doc/BRIEF.md
# Compact Floating-Point Add/Subtract Unit

This unit adds or subtracts two operands held in a 23-bit floating-point word. The word has a sign in bit 22, a 6-bit biased exponent in bits 21:16 (bias 31) and a 16-bit fraction in bits 15:0, with an implied leading one. It is meant for area-sensitive arithmetic datapaths such as audio transform engines, where full single precision costs more than the signal quality needs.

A strobe presents both operands and an operation-select bit. The unit then does three things in a single combinational path. First it aligns the operands and resolves the real add or subtract from both signs and the select bit. Then it combines the mantissas in a 17-bit adder that holds the hidden one. Last it renormalizes the raw sum back into the packed word. The result and its valid flag come from registers. Low-order bits are always truncated. There is no infinity, NaN or denormal handling: exponent overflow saturates and exponent underflow flushes to zero.

Top module: `fp23_addsub`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high, and `result` in that cycle is the outcome for the operands and select bit sampled with the strobe.
- R2: After synchronous reset, `out_valid` is 0 and `result` is 23'h000000.
- R3: With `op_sub` = 0, the result is the sum of the two operands. When both fractions fit without loss, the sum is exact (for example 1.0 + 0.5 = 0x1F8000, where 1.0 is 0x1F0000).
- R4: With `op_sub` = 1, the result is A minus B. The sign of B is inverted before the real operation is chosen, so the sign of the larger magnitude sets the result sign.
- R5: The smaller operand's mantissa is shifted right by the exponent difference and the shifted-out bits are dropped. A difference of 17 or more leaves the larger operand unchanged.
- R6: When the mantissa sum carries past the hidden-one position, the mantissa moves right by one (its lowest bit is dropped) and the exponent goes up by one.
- R7: When a subtraction produces leading zeros, the mantissa is shifted left until the hidden one is restored, and the exponent is reduced by the same count.
- R8: When a subtraction cancels exactly, the result is positive zero (0x000000).
- R9: An operand with exponent field 0 is zero, whatever its fraction. X plus or minus zero returns X with its sign adjusted by the operation, and zero combined with zero returns 0x000000.
- R10: If the result exponent would exceed 63, the output saturates to the largest finite magnitude with the result sign (exponent 63, fraction 0xFFFF).
- R11: If the result exponent would fall below 1, the output is flushed to 0x000000.
- R12: In a cycle without `in_valid`, `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and select bit are valid this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract B from A |
| opnd_a | input | 23 | Operand A (sign, exponent, fraction) |
| opnd_b | input | 23 | Operand B (sign, exponent, fraction) |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 23 | Registered result word |

## Verification
The properties check four things on every cycle. They check that the one-cycle strobe-to-valid relation holds, and that the result stays put between strobes. They check that any output with a zero exponent field is the all-zero word. They also check that an operand subtracted from itself, or combined with a zero operand, gives the expected word in the next cycle. Alignment truncation, carry and cancellation renormalization, saturation and flush-to-zero depend on the arithmetic value. Only the bench can show these, by comparing against its own integer model over directed corner operands and seeded random pairs whose exponents are often kept close together.

// File: rtl/fp23_pkg.sv
package fp23_pkg;
  localparam int unsigned FP_EXP_W  = 6;
  localparam int unsigned FP_FRAC_W = 16;
  localparam int unsigned FP_WORD_W = 1 + FP_EXP_W + FP_FRAC_W;
endpackage

// File: rtl/fp23_prenorm.sv
module fp23_prenorm #(
  parameter int unsigned EXP_W  = 6,
  parameter int unsigned FRAC_W = 16,
  localparam int unsigned WW    = 1 + EXP_W + FRAC_W,
  localparam int unsigned MW    = FRAC_W + 1
) (
  input  logic [WW-1:0]    a,
  input  logic [WW-1:0]    b,
  input  logic             op_sub,
  output logic [EXP_W-1:0] exp_big,
  output logic [MW-1:0]    mant_big,
  output logic [MW-1:0]    mant_small,
  output logic             sign_res,
  output logic             eff_sub
);
  logic             sa, sb, za, zb, a_ge;
  logic [EXP_W-1:0] ea, eb, e_sm, diff;
  logic [MW-1:0]    ma, mb, m_sm;
  logic [WW-2:0]    ka, kb;

  always_comb begin
    sa = a[WW-1];
    sb = b[WW-1] ^ op_sub;
    ea = a[WW-2 -: EXP_W];
    eb = b[WW-2 -: EXP_W];
    za = (ea == '0);
    zb = (eb == '0);
    ma = za ? '0 : {1'b1, a[FRAC_W-1:0]};
    mb = zb ? '0 : {1'b1, b[FRAC_W-1:0]};
    ka = za ? '0 : a[WW-2:0];
    kb = zb ? '0 : b[WW-2:0];
    a_ge = (ka >= kb);
    eff_sub  = sa ^ sb;
    sign_res = a_ge ? sa : sb;
    exp_big  = a_ge ? ea : eb;
    e_sm     = a_ge ? eb : ea;
    mant_big = a_ge ? ma : mb;
    m_sm     = a_ge ? mb : ma;
    diff     = exp_big - e_sm;
    if (int'(diff) >= MW) mant_small = '0;
    else                  mant_small = m_sm >> diff;
  end
endmodule

// File: rtl/fp23_mant_addsub.sv
module fp23_mant_addsub #(
  parameter int unsigned MW = 17
) (
  input  logic [MW-1:0] mant_big,
  input  logic [MW-1:0] mant_small,
  input  logic          eff_sub,
  output logic [MW:0]   sum
);
  always_comb begin
    if (eff_sub) sum = {1'b0, mant_big} - {1'b0, mant_small};
    else         sum = {1'b0, mant_big} + {1'b0, mant_small};
  end
endmodule

// File: rtl/fp23_postnorm.sv
module fp23_postnorm #(
  parameter int unsigned EXP_W  = 6,
  parameter int unsigned FRAC_W = 16,
  localparam int unsigned WW    = 1 + EXP_W + FRAC_W,
  localparam int unsigned MW    = FRAC_W + 1,
  localparam int unsigned LZW   = $clog2(MW + 1),
  localparam int unsigned XW    = EXP_W + 2,
  localparam int unsigned EMAX  = (1 << EXP_W) - 1
) (
  input  logic [MW:0]      sum,
  input  logic [EXP_W-1:0] exp_in,
  input  logic             sign_in,
  output logic [WW-1:0]    word
);
  logic [LZW-1:0] lz;
  logic           found;
  logic [XW-1:0]  e_x, e_up, e_dn, lz_x;
  logic [MW-1:0]  norm;

  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = MW - 1; i >= 0; i--) begin
      if (!found) begin
        if (sum[i]) found = 1'b1;
        else        lz    = lz + LZW'(1);
      end
    end
  end

  always_comb begin
    e_x  = XW'(exp_in);
    lz_x = XW'(lz);
    e_up = e_x + XW'(1);
    e_dn = e_x - lz_x;
    norm = sum[MW-1:0] << lz;
    if (sum == '0) begin
      word = '0;
    end else if (sum[MW]) begin
      if (e_up > XW'(EMAX)) word = {sign_in, {EXP_W{1'b1}}, {FRAC_W{1'b1}}};
      else                  word = {sign_in, e_up[EXP_W-1:0], sum[FRAC_W:1]};
    end else if (e_x <= lz_x) begin
      word = '0;
    end else begin
      word = {sign_in, e_dn[EXP_W-1:0], norm[FRAC_W-1:0]};
    end
  end
endmodule

// File: rtl/fp23_addsub.sv
module fp23_addsub #(
  parameter int unsigned EXP_W  = fp23_pkg::FP_EXP_W,
  parameter int unsigned FRAC_W = fp23_pkg::FP_FRAC_W,
  localparam int unsigned WW    = 1 + EXP_W + FRAC_W,
  localparam int unsigned MW    = FRAC_W + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          op_sub,
  input  logic [WW-1:0] opnd_a,
  input  logic [WW-1:0] opnd_b,
  output logic          out_valid,
  output logic [WW-1:0] result
);
  logic [EXP_W-1:0] exp_big;
  logic [MW-1:0]    mant_big, mant_small;
  logic             sign_res, eff_sub;
  logic [MW:0]      sum;
  logic [WW-1:0]    word;

  fp23_prenorm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pre (
    .a(opnd_a), .b(opnd_b), .op_sub(op_sub),
    .exp_big(exp_big), .mant_big(mant_big), .mant_small(mant_small),
    .sign_res(sign_res), .eff_sub(eff_sub)
  );

  fp23_mant_addsub #(.MW(MW)) u_add (
    .mant_big(mant_big), .mant_small(mant_small), .eff_sub(eff_sub), .sum(sum)
  );

  fp23_postnorm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_post (
    .sum(sum), .exp_in(exp_big), .sign_in(sign_res), .word(word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= word;
    end
  end
endmodule

// File: rtl/fp23_addsub_chk.sv
module fp23_addsub_chk #(
  parameter int unsigned EXP_W  = 6,
  parameter int unsigned FRAC_W = 16,
  localparam int unsigned WW    = 1 + EXP_W + FRAC_W
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          op_sub,
  input logic [WW-1:0] opnd_a,
  input logic [WW-1:0] opnd_b,
  input logic          out_valid,
  input logic [WW-1:0] result
);
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  p_zero_canon_r11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && result[WW-2 -: EXP_W] == '0) |-> (result == '0));
  p_self_cancel_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sub && opnd_a == opnd_b) |=> (result == '0));
  p_zero_operand_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opnd_a[WW-2 -: EXP_W] != '0 && opnd_b[WW-2 -: EXP_W] == '0)
      |=> (result == $past(opnd_a)));
endmodule

bind fp23_addsub fp23_addsub_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .result(result)
);

// File: tb/tb_fp23_addsub.sv
module tb_fp23_addsub;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        op_sub;
  logic [22:0] opnd_a, opnd_b;
  logic        out_valid;
  logic [22:0] result;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  fp23_addsub dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .result(result)
  );

  function automatic logic [22:0] model(input logic [22:0] a, input logic [22:0] b, input bit sub);
    int ea, eb, ma, mb, ka, kb, e, ms, d, s;
    bit sa, sb, sr;
    sa = a[22]; sb = b[22] ^ sub;
    ea = int'(a[21:16]); eb = int'(b[21:16]);
    ma = (ea == 0) ? 0 : 65536 + int'(a[15:0]);
    mb = (eb == 0) ? 0 : 65536 + int'(b[15:0]);
    ka = (ea == 0) ? 0 : ea * 65536 + int'(a[15:0]);
    kb = (eb == 0) ? 0 : eb * 65536 + int'(b[15:0]);
    if (ka >= kb) begin e = ea; s = ma; d = ea - eb; ms = mb; sr = sa; end
    else          begin e = eb; s = mb; d = eb - ea; ms = ma; sr = sb; end
    ms = (d >= 17) ? 0 : (ms >> d);
    s = (sa == sb) ? s + ms : s - ms;
    if (s == 0) return 23'h0;
    if (s >= 131072) begin s = s >> 1; e = e + 1; end
    while (s < 65536) begin s = s << 1; e = e - 1; end
    if (e > 63) return {sr, 6'h3F, 16'hFFFF};
    if (e < 1) return 23'h0;
    return {sr, 6'(e), 16'(s)};
  endfunction

  task automatic check(input string req, input logic [22:0] act, input logic [22:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [22:0] a, input logic [22:0] b,
                        input bit sub, input logic [22:0] exp);
    @(negedge clk);
    opnd_a = a; opnd_b = b; op_sub = sub; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " result"}, result, exp);
    check({req, " valid (R1)"}, {22'h0, out_valid}, 23'h1);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; op_sub = 1'b0; opnd_a = '0; opnd_b = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R2 reset result", result, 23'h0);
    check("R2 reset valid", {22'h0, out_valid}, 23'h0);

    run_op("R3 1.0+0.5", 23'h1F0000, 23'h1E0000, 0, 23'h1F8000);
    run_op("R6 1.0+1.0", 23'h1F0000, 23'h1F0000, 0, 23'h200000);
    run_op("R6 1.5+1.5", 23'h1F8000, 23'h1F8000, 0, 23'h208000);
    run_op("R4 2.0-1.0", 23'h200000, 23'h1F0000, 1, 23'h1F0000);
    run_op("R4 1.0-2.0", 23'h1F0000, 23'h200000, 1, 23'h5F0000);
    run_op("R4 -1.0+(+1.0 via sub of -1)", 23'h5F0000, 23'h5F0000, 1, 23'h000000);
    run_op("R7 1.0-0.75", 23'h1F0000, 23'h1E8000, 1, 23'h1D0000);
    run_op("R8 1.0-1.0", 23'h1F0000, 23'h1F0000, 1, 23'h000000);
    run_op("R8 1.0+(-1.0)", 23'h1F0000, 23'h5F0000, 0, 23'h000000);
    run_op("R5 diff17", 23'h1F0000, 23'h0EFFFF, 0, 23'h1F0000);
    run_op("R5 diff16", 23'h1F0000, 23'h0FFFFF, 0, 23'h1F0001);
    run_op("R5 truncate", 23'h1F0000, 23'h1E0001, 0, 23'h1F8000);
    run_op("R9 zero-exp with fraction", 23'h000123, 23'h1F0000, 0, 23'h1F0000);
    run_op("R9 x-0", 23'h1F0000, 23'h000000, 1, 23'h1F0000);
    run_op("R9 0-x", 23'h000000, 23'h1F0000, 1, 23'h5F0000);
    run_op("R9 0+0", 23'h400000, 23'h000000, 0, 23'h000000);
    run_op("R10 max+max", 23'h3FFFFF, 23'h3FFFFF, 0, 23'h3FFFFF);
    run_op("R10 neg sat", 23'h7F0000, 23'h7F0000, 0, 23'h7FFFFF);
    run_op("R11 flush", 23'h01FFFF, 23'h010000, 1, 23'h000000);

    // R12: change operands with no strobe; result must hold
    @(negedge clk);
    opnd_a = 23'h2A1234; opnd_b = 23'h123456; op_sub = 1'b0;
    @(negedge clk);
    check("R12 hold", result, 23'h000000);
    check("R1 idle valid", {22'h0, out_valid}, 23'h0);

    for (int i = 0; i < 3000; i++) begin
      logic [22:0] ra, rb;
      bit rs;
      ra = 23'($urandom);
      rb = 23'($urandom);
      rs = 1'($urandom);
      if ($urandom % 2 == 0) rb[21:16] = 6'(int'(ra[21:16]) + int'($urandom % 5) - 2);
      run_op("R3/R4/R5/R6/R7 random", ra, rb, rs, model(ra, rb, rs));
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule